// File: doc/BRIEF.md
# Dual-Style Microcontroller Slave Bus Interface

This block sits between an 8-bit microcontroller bus and a small internal register file. It turns asynchronous bus accesses into clean single-cycle register-file strobes in the internal clock domain. A static style input picks one of two strobe conventions. In the first, separate active-low read and write strobes are used. In the second, an active-low data strobe is qualified by a direction line.

A second static input chooses how the register address arrives. In direct mode, three address pins give the index. In multiplexed mode, the low three data lines carry the index. An address-latch-enable pulse captures it, and after that those lines carry data again. Data lines 3 to 7 only ever carry data.

Every recognised access gives exactly one write-enable pulse or one read-fetch pulse. Read data is driven back onto the bus under a data-bus output enable, and that enable is active only while a read with chip select is in progress. A pending-condition input and an enable input combine into an active-low interrupt output.

Top module: `mcu_bus_if`

## Requirements
- R1: While and after an asynchronous active-low reset, regWe, regRe, dataOe, regIdx, regWdata and dataOut are all 0 (with csN held high).
- R2: With muxModeN = 1 (direct mode), the register index of an access equals addrIn, where bit 0 is the least significant bit.
- R3: With muxModeN = 0 (multiplexed mode), the index is taken from dataIn[2:0] while ale is high and is held after ale falls. In this mode addrIn has no effect on regIdx.
- R4: In both modes, regWdata receives all eight dataIn bits present during the write strobe. dataIn[7:3] never affects the index.
- R5: With styleSel = 0, holding wrDirN low with csN low gives exactly one regWe pulse, and regWdata then equals the bus data.
- R6: With styleSel = 0, holding rdStrobeN low with csN low gives exactly one regRe pulse. dataOut then equals regRdata for that index.
- R7: With styleSel = 1, rdStrobeN acts as the data strobe. wrDirN = 1 selects a read and wrDirN = 0 selects a write.
- R8: While csN is high, strobes produce no regWe pulse, no regRe pulse and no dataOe.
- R9: dataOe is 1 only while a read with csN low is asserted. It is 0 during writes and when the bus is idle.
- R10: A strobe held for many cycles still produces only one pulse, and regWe and regRe are never both high.
- R11: irqN is 0 exactly when irqPend and irqEn are both 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| styleSel | input | 1 | 0: separate read/write strobes, 1: data strobe plus direction |
| muxModeN | input | 1 | 0: multiplexed address/data, 1: direct address pins |
| addrIn | input | 3 | Direct-mode register address |
| ale | input | 1 | Address latch enable (multiplexed mode) |
| dataIn | input | 8 | Bus data in (low 3 bits also address in multiplexed mode) |
| dataOut | output | 8 | Bus read data |
| dataOe | output | 1 | Bus output enable, active high |
| csN | input | 1 | Active-low chip select |
| rdStrobeN | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| wrDirN | input | 1 | Write strobe active low (style 0) or direction, 1 = read (style 1) |
| regIdx | output | 3 | Register-file index |
| regWe | output | 1 | Register-file write enable, one cycle per write |
| regWdata | output | 8 | Register-file write data |
| regRe | output | 1 | Read-fetch pulse, one cycle per read |
| regRdata | input | 8 | Register-file read data for regIdx |
| irqPend | input | 1 | Pending interrupt condition |
| irqEn | input | 1 | Interrupt enable |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bench drives strobes held for many cycles. A level-sensitive design would then pulse regWe on every cycle, while a correct one counts a single pulse. In multiplexed mode the bench drives addrIn with the complement of the latched address, so a design that reads the wrong address source gives an inverted index. It also changes dataIn[2:0] to write data after ale falls, which exposes a latch that stays transparent. Accesses with csN high, and writes in both strobe styles, check that no pulse appears and that dataOe stays low. A swapped direction polarity in the data-strobe style would turn writes into reads.

// File: rtl/mcu_bus_if_pkg.sv
package mcu_bus_if_pkg;
  typedef struct packed {
    logic capWr;  // latch index and write data
    logic capRd;  // latch index for a read
    logic fetch;  // load read data from register file
  } busStrb_t;
endpackage

// File: rtl/mcu_bus_if_ctrl.sv
module mcu_bus_if_ctrl
  import mcu_bus_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     styleSel,
  input  logic     csN,
  input  logic     rdStrobeN,
  input  logic     wrDirN,
  output busStrb_t strb,
  output logic     regWe,
  output logic     regRe,
  output logic     dataOe
);
  logic rdRaw, wrRaw;
  logic [SYNC_STAGES:0] rdPipe, wrPipe;
  logic rdEdge, wrEdge;

  always_comb begin
    if (styleSel) begin
      rdRaw = !csN && !rdStrobeN && wrDirN;
      wrRaw = !csN && !rdStrobeN && !wrDirN;
    end else begin
      rdRaw = !csN && !rdStrobeN;
      wrRaw = !csN && !wrDirN && rdStrobeN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe <= '0;
      wrPipe <= '0;
    end else begin
      rdPipe <= {rdPipe[SYNC_STAGES-1:0], rdRaw};
      wrPipe <= {wrPipe[SYNC_STAGES-1:0], wrRaw};
    end
  end

  assign rdEdge = rdPipe[SYNC_STAGES-1] && !rdPipe[SYNC_STAGES];
  assign wrEdge = wrPipe[SYNC_STAGES-1] && !wrPipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWe <= 1'b0;
      regRe <= 1'b0;
    end else begin
      regWe <= wrEdge;
      regRe <= rdEdge && !wrEdge;
    end
  end

  assign strb.capWr = wrEdge;
  assign strb.capRd = rdEdge && !wrEdge;
  assign strb.fetch = regRe;
  assign dataOe     = rdRaw && rstN;
endmodule

// File: rtl/mcu_bus_if_dp.sv
module mcu_bus_if_dp
  import mcu_bus_if_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              muxModeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ale,
  input  logic [DATA_W-1:0] dataIn,
  input  busStrb_t          strb,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] regIdx,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] dataOut
);
  logic [SYNC_STAGES-1:0] alePipe;
  logic [ADDR_W-1:0]      addrLatch;
  logic [ADDR_W-1:0]      addrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alePipe   <= '0;
      addrLatch <= '0;
    end else begin
      alePipe <= {alePipe[SYNC_STAGES-2:0], ale};
      if (alePipe[SYNC_STAGES-1]) addrLatch <= dataIn[ADDR_W-1:0];
    end
  end

  assign addrSel = muxModeN ? addrIn : addrLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regIdx   <= '0;
      regWdata <= '0;
      dataOut  <= '0;
    end else begin
      if (strb.capWr || strb.capRd) regIdx <= addrSel;
      if (strb.capWr) regWdata <= dataIn;
      if (strb.fetch) dataOut <= regRdata;
    end
  end
endmodule

// File: rtl/mcu_bus_if.sv
module mcu_bus_if
  import mcu_bus_if_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              styleSel,
  input  logic              muxModeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ale,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic              csN,
  input  logic              rdStrobeN,
  input  logic              wrDirN,
  output logic [ADDR_W-1:0] regIdx,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              irqPend,
  input  logic              irqEn,
  output logic              irqN
);
  busStrb_t strb;

  mcu_bus_if_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .styleSel(styleSel), .csN(csN),
    .rdStrobeN(rdStrobeN), .wrDirN(wrDirN), .strb(strb),
    .regWe(regWe), .regRe(regRe), .dataOe(dataOe)
  );

  mcu_bus_if_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .muxModeN(muxModeN), .addrIn(addrIn),
    .ale(ale), .dataIn(dataIn), .strb(strb), .regRdata(regRdata),
    .regIdx(regIdx), .regWdata(regWdata), .dataOut(dataOut)
  );

  assign irqN = !(irqPend && irqEn);
endmodule

// File: rtl/mcu_bus_if_chk.sv
module mcu_bus_if_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic dataOe,
  input logic regWe,
  input logic regRe,
  input logic irqPend,
  input logic irqEn,
  input logic irqN
);
  assert_single_we_R10: assert property (@(posedge clk) disable iff (!rstN) regWe |=> !regWe);
  assert_single_re_R10: assert property (@(posedge clk) disable iff (!rstN) regRe |=> !regRe);
  assert_we_re_excl_R10: assert property (@(posedge clk) disable iff (!rstN) !(regWe && regRe));
  assert_oe_needs_cs_R9: assert property (@(posedge clk) disable iff (!rstN) dataOe |-> !csN);
  assert_irq_cond_R11: assert property (@(posedge clk) disable iff (!rstN) !irqN |-> (irqPend && irqEn));
endmodule

bind mcu_bus_if mcu_bus_if_chk chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .dataOe(dataOe), .regWe(regWe),
  .regRe(regRe), .irqPend(irqPend), .irqEn(irqEn), .irqN(irqN)
);

// File: tb/mcu_bus_if_tb_top.sv
module mcu_bus_if_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic styleSel = 1'b0, muxModeN = 1'b1, ale = 1'b0;
  logic [2:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic csN = 1'b1, rdStrobeN = 1'b1, wrDirN = 1'b1;
  logic irqPend = 1'b0, irqEn = 1'b0;
  logic [7:0] dataOut, regWdata, regRdata;
  logic dataOe, regWe, regRe, irqN;
  logic [2:0] regIdx;

  int checks = 0, fails = 0;
  int weCnt = 0, reCnt = 0;
  logic [2:0] weIdx, reIdx;
  logic [7:0] weData;
  logic oeMid;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] model(input logic [2:0] i);
    return {i, 5'b10110} ^ 8'h5A;
  endfunction
  assign regRdata = model(regIdx);

  mcu_bus_if dut_i (
    .clk(clk), .rstN(rstN), .styleSel(styleSel), .muxModeN(muxModeN),
    .addrIn(addrIn), .ale(ale), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .csN(csN), .rdStrobeN(rdStrobeN), .wrDirN(wrDirN),
    .regIdx(regIdx), .regWe(regWe), .regWdata(regWdata), .regRe(regRe),
    .regRdata(regRdata), .irqPend(irqPend), .irqEn(irqEn), .irqN(irqN)
  );

  always @(negedge clk) begin
    if (regWe) begin weCnt++; weIdx = regIdx; weData = regWdata; end
    if (regRe) begin reCnt++; reIdx = regIdx; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit rd, input logic [2:0] a, input logic [7:0] d,
                        input bit useCs, input int hold);
    @(negedge clk);
    if (!muxModeN) begin
      dataIn = {d[7:3], a};
      ale = 1'b1;
      repeat (3) @(negedge clk);
      ale = 1'b0;
      repeat (3) @(negedge clk);
      addrIn = ~a;
    end else begin
      addrIn = a;
    end
    dataIn = rd ? 8'h00 : d;
    if (styleSel) wrDirN = rd;
    @(negedge clk);
    csN = !useCs;
    if (styleSel || rd) rdStrobeN = 1'b0;
    else wrDirN = 1'b0;
    repeat (hold) @(negedge clk);
    oeMid = dataOe;
    rdStrobeN = 1'b1;
    wrDirN = 1'b1;
    csN = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 idle oe", dataOe, 0);
  endtask

  task automatic tReset;
    repeat (3) @(negedge clk);
    check("R1 regWe", regWe, 0);
    check("R1 regRe", regRe, 0);
    check("R1 dataOe", dataOe, 0);
    check("R1 regIdx", regIdx, 0);
    check("R1 regWdata", regWdata, 0);
    check("R1 dataOut", dataOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tWrite(input string req, input logic [2:0] a, input logic [7:0] d, input int hold);
    int w0 = weCnt, r0 = reCnt;
    access(1'b0, a, d, 1'b1, hold);
    check({req, " R10 we count"}, weCnt - w0, 1);
    check({req, " no re"}, reCnt - r0, 0);
    check({req, " idx R2/R3"}, weIdx, a);
    check({req, " data R4"}, weData, d);
    check({req, " oe during write R9"}, oeMid, 0);
  endtask

  task automatic tRead(input string req, input logic [2:0] a);
    int w0 = weCnt, r0 = reCnt;
    access(1'b1, a, 8'h00, 1'b1, 8);
    check({req, " re count R10"}, reCnt - r0, 1);
    check({req, " no we"}, weCnt - w0, 0);
    check({req, " idx"}, reIdx, a);
    check({req, " dataOut"}, dataOut, model(a));
    check({req, " oe during read R9"}, oeMid, 1);
  endtask

  task automatic tNoCs;
    int w0 = weCnt, r0 = reCnt;
    access(1'b0, 3'd6, 8'hEE, 1'b0, 8);
    access(1'b1, 3'd6, 8'h00, 1'b0, 8);
    check("R8 no we without cs", weCnt - w0, 0);
    check("R8 no re without cs", reCnt - r0, 0);
    check("R8 no oe without cs", oeMid, 0);
  endtask

  task automatic tIrq;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      irqPend = k[0];
      irqEn = k[1];
      #1;
      check("R11 irqN", irqN, (k == 3) ? 0 : 1);
    end
    irqPend = 1'b0; irqEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tReset();
    styleSel = 1'b0; muxModeN = 1'b1;
    tWrite("R5 style0 direct", 3'd5, 8'hA7, 8);
    tRead("R6 style0 direct", 3'd3);
    tWrite("R10 long strobe", 3'd1, 8'h3C, 40);
    styleSel = 1'b1;
    tWrite("R7 style1 write", 3'd2, 8'h96, 8);
    tRead("R7 style1 read", 3'd7);
    muxModeN = 1'b0;
    tWrite("R3 mux style1", 3'd4, 8'hF9, 8);
    tRead("R3 mux style1", 3'd6);
    styleSel = 1'b0;
    tWrite("R3 mux style0", 3'd1, 8'h5B, 8);
    tRead("R3 mux style0", 3'd0);
    muxModeN = 1'b1;
    tNoCs();
    tIrq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule